// File: doc/BRIEF.md
# Instruction-Cycle Timing Sequencer

This block is the hardwired timing and control front end of a small 16-bit accumulator machine. A 4-bit step counter is decoded into sixteen one-hot timing lines, T0 to T15. Each instruction walks through a chain of these lines. The chain always starts with three fetch and decode steps and then runs an execute tail whose length depends on the opcode. At the last step of every instruction the counter is cleared synchronously, so the next instruction always begins at T0. The counter is never free-running.

The block holds the registers that the fetch touches: the program counter, the address register, the instruction register, the latched opcode and the mode flag. Toward an external data-register, accumulator and memory model it drives a common-bus source select and the load, increment and write strobes of the execute steps. A 16-bit instruction word carries the address field in bits 11:0, the opcode in bits 14:12 and the mode bit in bit 15. Memory returns the addressed word in the same cycle, so no wait states are inserted.

The sequence has four phases, each chosen by the active timing line. ADDR (T0) moves PC into AR. READ (T1) loads IR from memory and increments PC. DECODE (T2) moves the address field into AR and latches the opcode and the mode bit. EXEC (T3 and later) runs the opcode's tail. ADDR always goes to READ, READ to DECODE, and DECODE to EXEC. EXEC steps T3→T4→… and returns to ADDR on the opcode's final step.

Top module: `timing_sequencer`

## Requirements
- R1: A synchronous active-high `rst` makes T0 active on the following cycle and clears `pc` to 0 and `d_sig` to all zeros. This holds even when `rst` arrives in the middle of an instruction.
- R2: Exactly one bit of `t_sig` is set in every cycle. If the counter is not cleared, the active bit moves up by one position at each rising edge.
- R3: During T0, `bus_sel` is 3'b010 (program counter). After the edge, `mem_addr` equals the value `pc` had in T0.
- R4: During T1, `bus_sel` is 3'b111 (memory word) and IR loads `mem_rdata`. After the edge, `pc` has increased by one.
- R5: During T2, `bus_sel` is 3'b101 (instruction register). After the edge, `mem_addr` equals instruction bits 11:0 and `mode` equals instruction bit 15.
- R6: From T3 until the next instruction's T2, `d_sig` is the one-hot code of instruction bits 14:12 (bit n for opcode n). Before the first decode after reset, `d_sig` is all zeros.
- R7: The counter is cleared with the last step of each instruction, and T0 follows. The last step is T5 for opcodes 0, 1, 2 and 5, T4 for opcodes 3 and 4, T6 for opcode 6, and T3 for opcode 7.
- R8: Opcodes 0, 1 and 2 use two steps. T4 has `bus_sel` 3'b111 and `dr_ld`. T5 has `ac_ld` with `alu_fn` 2'b00, 2'b01 or 2'b10 for opcode 0, 1 or 2 respectively, and no bus source (3'b000).
- R9: Opcode 3 drives `bus_sel` 3'b100 (accumulator) with `mem_wr` during T4.
- R10: Opcode 4 drives `bus_sel` 3'b001 (address register) during T4 and loads PC from AR. The next instruction is fetched from the address field.
- R11: Opcode 5 drives `bus_sel` 3'b010 with `mem_wr` during T4, at `mem_addr` equal to the address field, and then increments AR. During T5 it drives `bus_sel` 3'b001 and loads PC from AR. The next fetch address is the address field plus one.
- R12: Opcode 6 has `bus_sel` 3'b111 with `dr_ld` in T4, `dr_inc` in T5, and `bus_sel` 3'b011 with `mem_wr` in T6. PC advances by one extra if `dr_zero` is high during T6.
- R13: T3 is idle for opcodes 0 to 6: no strobe is active and `bus_sel` is 3'b000. In any cycle, at most one register takes a load from the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_rdata | input | 16 | Memory word at `mem_addr`, valid in the same cycle |
| dr_zero | input | 1 | Data register is zero (sampled in T6 of opcode 6) |
| mem_addr | output | 12 | Address register contents, used as the memory address |
| pc | output | 12 | Program counter |
| mode | output | 1 | Mode flag latched from instruction bit 15 |
| t_sig | output | 16 | One-hot timing lines T0..T15 |
| d_sig | output | 8 | One-hot opcode lines D0..D7 |
| bus_sel | output | 3 | Common-bus source select |
| dr_ld | output | 1 | Data register load from bus |
| dr_inc | output | 1 | Data register increment |
| ac_ld | output | 1 | Accumulator load from ALU |
| alu_fn | output | 2 | ALU function for `ac_ld` |
| mem_wr | output | 1 | Memory write of the bus value at `mem_addr` |

## Verification
Two situations are the hardest to reach from the ports. The first is a reset that lands in the middle of an execute tail, after the opcode register already holds a decode. The second is the opcode-6 skip, which depends on `dr_zero` being sampled in exactly one cycle. The stimulus sweeps every opcode against both mode values and both `dr_zero` levels. It places each instruction word at the address the bench expects the fetch to use next, so branches and skips are confirmed by where the following fetch lands. A final run forces reset during T4, then checks that the fetch restarts cleanly at address zero.

// File: rtl/tseq_pkg.sv
package tseq_pkg;

    typedef enum logic [2:0] {
        BUS_NONE = 3'd0,
        BUS_AR   = 3'd1,
        BUS_PC   = 3'd2,
        BUS_DR   = 3'd3,
        BUS_AC   = 3'd4,
        BUS_IR   = 3'd5,
        BUS_MEM  = 3'd7
    } bus_src_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_READ,
        PH_DECODE,
        PH_EXEC
    } phase_e;

    // strobes toward the external data path
    typedef struct packed {
        bus_src_e   bus;
        logic       dr_ld;
        logic       dr_inc;
        logic       ac_ld;
        logic [1:0] alu;
        logic       mem_wr;
    } dp_ctl_t;

    // strobes toward the fetch registers held inside the block
    typedef struct packed {
        logic ar_from_pc;
        logic ar_from_ir;
        logic ar_inc;
        logic ir_ld;
        logic pc_inc;
        logic pc_from_ar;
        logic op_ld;
    } fr_ctl_t;

endpackage

// File: rtl/step_counter.sv
module step_counter #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + CW'(1);
        end
    end

    // R2: clear wins over increment
    a_r2_clear_wins: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));

    // R2: plain step moves up by one
    a_r2_step_up: assert property (@(posedge clk) disable iff (rst)
        (!clr && inc) |=> (cnt == $past(cnt) + CW'(1)));

endmodule

// File: rtl/onehot_dec.sv
module onehot_dec #(
    parameter int IW = 3
) (
    input  logic              en,
    input  logic [IW-1:0]     code,
    output logic [2**IW-1:0]  lines
);

    localparam int NL = 2**IW;

    for (genvar i = 0; i < NL; i++) begin : g_line
        assign lines[i] = en && (code == IW'(i));
    end

endmodule

// File: rtl/fetch_regs.sv
module fetch_regs
    import tseq_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  fr_ctl_t       c,
    input  logic [AW+3:0] mem_rdata,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] ar,
    output logic          mode,
    output logic [2:0]    opcode,
    output logic          op_valid
);

    localparam int WW  = AW + 4;
    localparam int OPL = AW;

    logic [WW-1:0] ir;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc       <= '0;
            ar       <= '0;
            ir       <= '0;
            mode     <= 1'b0;
            opcode   <= '0;
            op_valid <= 1'b0;
        end else begin
            if (c.ar_from_pc) begin
                ar <= pc;
            end else if (c.ar_from_ir) begin
                ar <= ir[AW-1:0];
            end else if (c.ar_inc) begin
                ar <= ar + AW'(1);
            end

            if (c.ir_ld) begin
                ir <= mem_rdata;
            end

            if (c.pc_from_ar) begin
                pc <= ar;
            end else if (c.pc_inc) begin
                pc <= pc + AW'(1);
            end

            if (c.op_ld) begin
                opcode   <= ir[OPL+2:OPL];
                mode     <= ir[WW-1];
                op_valid <= 1'b1;
            end
        end
    end

    // R4: increment of PC seen on the next cycle
    a_r4_pc_step: assert property (@(posedge clk) disable iff (rst)
        (c.pc_inc && !c.pc_from_ar) |=> (pc == $past(pc) + AW'(1)));

    // R5: mode and opcode taken from the instruction held during decode
    a_r5_mode_latch: assert property (@(posedge clk) disable iff (rst)
        c.op_ld |=> (mode == $past(ir[WW-1])) && (opcode == $past(ir[OPL+2:OPL])));

    // R10: jump transfers the address register into PC
    a_r10_pc_from_ar: assert property (@(posedge clk) disable iff (rst)
        c.pc_from_ar |=> (pc == $past(ar)));

endmodule

// File: rtl/step_control.sv
module step_control
    import tseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] t_sig,
    input  logic [7:0]  d_sig,
    input  logic        dr_zero,
    output logic        sc_clr,
    output logic        sc_inc,
    output fr_ctl_t     fr,
    output dp_ctl_t     dp
);

    phase_e phase;
    logic   grp_alu;
    logic   overrun;

    always_comb begin
        if (t_sig[0]) begin
            phase = PH_ADDR;
        end else if (t_sig[1]) begin
            phase = PH_READ;
        end else if (t_sig[2]) begin
            phase = PH_DECODE;
        end else begin
            phase = PH_EXEC;
        end
    end

    assign grp_alu = d_sig[0] | d_sig[1] | d_sig[2];
    // a timing line beyond the longest tail forces a restart
    assign overrun = |t_sig[15:7];

    always_comb begin
        fr     = '0;
        dp     = '0;
        dp.bus = BUS_NONE;
        sc_clr = 1'b0;
        unique case (phase)
            PH_ADDR: begin
                dp.bus        = BUS_PC;
                fr.ar_from_pc = 1'b1;
            end
            PH_READ: begin
                dp.bus    = BUS_MEM;
                fr.ir_ld  = 1'b1;
                fr.pc_inc = 1'b1;
            end
            PH_DECODE: begin
                dp.bus        = BUS_IR;
                fr.ar_from_ir = 1'b1;
                fr.op_ld      = 1'b1;
            end
            PH_EXEC: begin
                if (d_sig[7] && t_sig[3]) begin
                    sc_clr = 1'b1;
                end
                if (grp_alu && t_sig[4]) begin
                    dp.bus   = BUS_MEM;
                    dp.dr_ld = 1'b1;
                end
                if (grp_alu && t_sig[5]) begin
                    dp.ac_ld = 1'b1;
                    dp.alu   = {d_sig[2], d_sig[1]};
                    sc_clr   = 1'b1;
                end
                if (d_sig[3] && t_sig[4]) begin
                    dp.bus    = BUS_AC;
                    dp.mem_wr = 1'b1;
                    sc_clr    = 1'b1;
                end
                if (d_sig[4] && t_sig[4]) begin
                    dp.bus        = BUS_AR;
                    fr.pc_from_ar = 1'b1;
                    sc_clr        = 1'b1;
                end
                if (d_sig[5] && t_sig[4]) begin
                    dp.bus    = BUS_PC;
                    dp.mem_wr = 1'b1;
                    fr.ar_inc = 1'b1;
                end
                if (d_sig[5] && t_sig[5]) begin
                    dp.bus        = BUS_AR;
                    fr.pc_from_ar = 1'b1;
                    sc_clr        = 1'b1;
                end
                if (d_sig[6] && t_sig[4]) begin
                    dp.bus   = BUS_MEM;
                    dp.dr_ld = 1'b1;
                end
                if (d_sig[6] && t_sig[5]) begin
                    dp.dr_inc = 1'b1;
                end
                if (d_sig[6] && t_sig[6]) begin
                    dp.bus    = BUS_DR;
                    dp.mem_wr = 1'b1;
                    fr.pc_inc = dr_zero;
                    sc_clr    = 1'b1;
                end
                if (overrun) begin
                    sc_clr = 1'b1;
                end
            end
        endcase
    end

    assign sc_inc = !sc_clr;

    // R13: no two registers take a bus load in the same cycle
    a_r13_single_load: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fr.ar_from_pc, fr.ar_from_ir, fr.ir_ld, dp.dr_ld, dp.ac_ld, fr.pc_from_ar}));

    // R9: memory is never written during fetch or decode
    a_r9_write_late: assert property (@(posedge clk) disable iff (rst)
        dp.mem_wr |-> (t_sig[2:0] == 3'b000));

endmodule

// File: rtl/timing_sequencer.sv
module timing_sequencer
    import tseq_pkg::*;
#(
    parameter int AW = 12,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW+3:0] mem_rdata,
    input  logic          dr_zero,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] pc,
    output logic          mode,
    output logic [15:0]   t_sig,
    output logic [7:0]    d_sig,
    output logic [2:0]    bus_sel,
    output logic          dr_ld,
    output logic          dr_inc,
    output logic          ac_ld,
    output logic [1:0]    alu_fn,
    output logic          mem_wr
);

    localparam int NT  = 2**CW;
    localparam int OPW = 3;

    logic [CW-1:0] sc;
    logic          sc_clr;
    logic          sc_inc;
    logic [2:0]    opcode;
    logic          op_valid;
    logic [NT-1:0] t_lines;
    fr_ctl_t       fr;
    dp_ctl_t       dp;

    step_counter #(.CW(CW)) u_sc (
        .clk (clk),
        .rst (rst),
        .clr (sc_clr),
        .inc (sc_inc),
        .cnt (sc)
    );

    onehot_dec #(.IW(CW)) u_tdec (
        .en    (1'b1),
        .code  (sc),
        .lines (t_lines)
    );

    onehot_dec #(.IW(OPW)) u_ddec (
        .en    (op_valid),
        .code  (opcode),
        .lines (d_sig)
    );

    fetch_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .c         (fr),
        .mem_rdata (mem_rdata),
        .pc        (pc),
        .ar        (mem_addr),
        .mode      (mode),
        .opcode    (opcode),
        .op_valid  (op_valid)
    );

    step_control u_ctl (
        .clk     (clk),
        .rst     (rst),
        .t_sig   (t_sig),
        .d_sig   (d_sig),
        .dr_zero (dr_zero),
        .sc_clr  (sc_clr),
        .sc_inc  (sc_inc),
        .fr      (fr),
        .dp      (dp)
    );

    assign t_sig   = t_lines[15:0];
    assign bus_sel = dp.bus;
    assign dr_ld   = dp.dr_ld;
    assign dr_inc  = dp.dr_inc;
    assign ac_ld   = dp.ac_ld;
    assign alu_fn  = dp.alu;
    assign mem_wr  = dp.mem_wr;

    // R2: timing lines are one-hot
    a_r2_t_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot(t_sig));

    // R6: opcode lines carry at most one bit
    a_r6_d_onehot0: assert property (@(posedge clk) disable iff (rst)
        $onehot0(d_sig));

    // R7: a cleared counter restarts at T0
    a_r7_restart: assert property (@(posedge clk) disable iff (rst)
        sc_clr |=> t_sig[0]);

    // R7: no tail runs past T6
    a_r7_sc_bound: assert property (@(posedge clk) disable iff (rst)
        sc <= CW'(6));

    // R3: address register takes PC at the end of T0
    a_r3_ar_from_pc: assert property (@(posedge clk) disable iff (rst)
        t_sig[0] |=> (mem_addr == $past(pc)));

endmodule

// File: tb/timing_sequencer_test.sv
module timing_sequencer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_rdata;
    logic        dr_zero = 1'b0;
    logic [11:0] mem_addr;
    logic [11:0] pc;
    logic        mode;
    logic [15:0] t_sig;
    logic [7:0]  d_sig;
    logic [2:0]  bus_sel;
    logic        dr_ld, dr_inc, ac_ld, mem_wr;
    logic [1:0]  alu_fn;

    logic [15:0] mem [0:63];
    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;

    logic [11:0] exp_pc;
    logic [2:0]  prev_op;
    logic        prev_valid;

    always #2.5 clk = ~clk;

    assign mem_rdata = mem[mem_addr[5:0]];

    timing_sequencer uut (
        .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .dr_zero(dr_zero),
        .mem_addr(mem_addr), .pc(pc), .mode(mode), .t_sig(t_sig), .d_sig(d_sig),
        .bus_sel(bus_sel), .dr_ld(dr_ld), .dr_inc(dr_inc), .ac_ld(ac_ld),
        .alu_fn(alu_fn), .mem_wr(mem_wr)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 20000) begin
            n_fails++;
            $display("FAIL R7 watchdog expired act=%0d exp=<20000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic int last_step(input logic [2:0] op);
        case (op)
            3'd3, 3'd4: return 4;
            3'd6:       return 6;
            3'd7:       return 3;
            default:    return 5;
        endcase
    endfunction

    function automatic string op_req(input logic [2:0] op);
        case (op)
            3'd0, 3'd1, 3'd2: return "R8";
            3'd3:             return "R9";
            3'd4:             return "R10";
            3'd5:             return "R11";
            3'd6:             return "R12";
            default:          return "R7";
        endcase
    endfunction

    // {bus[2:0], dr_ld, dr_inc, ac_ld, alu[1:0], mem_wr}
    function automatic logic [8:0] exp_ctl(input logic [2:0] op, input int k);
        logic [8:0] v = '0;
        case (k)
            0: v[8:6] = 3'b010;
            1: v[8:6] = 3'b111;
            2: v[8:6] = 3'b101;
            4: case (op)
                   3'd0, 3'd1, 3'd2, 3'd6: begin v[8:6] = 3'b111; v[5] = 1'b1; end
                   3'd3: begin v[8:6] = 3'b100; v[0] = 1'b1; end
                   3'd4: v[8:6] = 3'b001;
                   3'd5: begin v[8:6] = 3'b010; v[0] = 1'b1; end
                   default: v = '0;
               endcase
            5: case (op)
                   3'd0, 3'd1, 3'd2: begin v[3] = 1'b1; v[2:1] = op[1:0]; end
                   3'd5: v[8:6] = 3'b001;
                   3'd6: v[4] = 1'b1;
                   default: v = '0;
               endcase
            6: if (op == 3'd6) begin v[8:6] = 3'b011; v[0] = 1'b1; end
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic run_instr(input logic [2:0] op, input logic md, input logic [11:0] addr, input logic dz);
        int last;
        logic [11:0] p;
        logic [8:0] act_ctl;
        logic [8:0] want;
        last = last_step(op);
        p = exp_pc;
        mem[p[5:0]] = {md, op, addr};
        dr_zero = dz;
        for (int k = 0; k <= last; k++) begin
            check(t_sig == (16'h1 << k), (k == 0) ? "R7" : "R2", {16'h0, t_sig}, 32'h1 << k);
            act_ctl = {bus_sel, dr_ld, dr_inc, ac_ld, alu_fn, mem_wr};
            want = exp_ctl(op, k);
            check(act_ctl == want,
                  (k == 0) ? "R3" : (k == 1) ? "R4" : (k == 2) ? "R5" : (k == 3) ? "R13" : op_req(op),
                  {23'h0, act_ctl}, {23'h0, want});
            if (k == 0)
                check(pc == p, prev_valid ? op_req(prev_op) : "R1", {20'h0, pc}, {20'h0, p});
            if (k >= 2)
                check(pc == p + 12'd1, "R4", {20'h0, pc}, {20'h0, p + 12'd1});
            if (k == 1 || k == 2)
                check(mem_addr == p, "R3", {20'h0, mem_addr}, {20'h0, p});
            if (k >= 3) begin
                logic [11:0] ea = (op == 3'd5 && k == 5) ? addr + 12'd1 : addr;
                check(mem_addr == ea, (op == 3'd5) ? "R11" : "R5", {20'h0, mem_addr}, {20'h0, ea});
                check(mode == md, "R5", {31'h0, mode}, {31'h0, md});
                check(d_sig == (8'h1 << op), "R6", {24'h0, d_sig}, 32'h1 << op);
            end else begin
                logic [7:0] ed = prev_valid ? (8'h1 << prev_op) : 8'h0;
                check(d_sig == ed, "R6", {24'h0, d_sig}, {24'h0, ed});
            end
            @(negedge clk);
        end
        case (op)
            3'd4:    exp_pc = addr;
            3'd5:    exp_pc = addr + 12'd1;
            3'd6:    exp_pc = p + 12'd1 + {11'h0, dz};
            default: exp_pc = p + 12'd1;
        endcase
        prev_op = op;
        prev_valid = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        exp_pc = '0;
        prev_op = '0;
        prev_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(t_sig == 16'h1, "R1", {16'h0, t_sig}, 32'h1);
        check(pc == 12'h0, "R1", {20'h0, pc}, 32'h0);
        check(d_sig == 8'h0, "R1", {24'h0, d_sig}, 32'h0);
        rst = 1'b0;

        for (int op = 0; op < 8; op++) begin
            for (int md = 0; md < 2; md++) begin
                for (int dz = 0; dz < 2; dz++) begin
                    logic [11:0] a;
                    a = 12'(((op * 9 + md * 5 + dz * 3 + 2) % 60) + 1);
                    run_instr(3'(op), md[0], a, dz[0]);
                end
            end
        end

        // R1: reset arriving in T4 of a long instruction
        mem[exp_pc[5:0]] = {1'b0, 3'd6, 12'd20};
        repeat (4) @(negedge clk);
        check(t_sig == 16'h10, "R1", {16'h0, t_sig}, 32'h10);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(t_sig == 16'h1, "R1", {16'h0, t_sig}, 32'h1);
        check(pc == 12'h0, "R1", {20'h0, pc}, 32'h0);
        check(d_sig == 8'h0, "R1", {24'h0, d_sig}, 32'h0);
        exp_pc = '0;
        prev_valid = 1'b0;
        run_instr(3'd6, 1'b1, 12'd33, 1'b1);
        run_instr(3'd7, 1'b0, 12'd5, 1'b0);
        check(pc == exp_pc, "R12", {20'h0, pc}, {20'h0, exp_pc});

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule